// File: doc/BRIEF.md
# Shared-Line Bus Hand-Over Controller

This block decides when the local bus goes to an outside master and when it comes back. Each outside master has one active-low line that both sides use. The master pulses the line low for one clock to ask for the bus. The controller answers on the same line with a one-clock low pulse once the bus cycle in progress allows a hand-over. From then on the controller's bus drivers float. A second one-clock low pulse from the master ends the exchange, and the controller takes the bus back on the following clock.

Channel 0 wins over channel 1. When a bus cycle is running, the hand-over happens only at its last T-state, and only if four conditions on that cycle allow it. When the bus is idle, the grant goes out on the very next clock. A request that arrives while another exchange is in progress is held until the hand-back is complete.

The cycle phase comes in on `cyc_st` with this encoding: 0 idle bus, 1 first, 2 second, 3 third, 4 wait, 5 last T-state.

Top module: `rqgt_exchange`

## Requirements
- R1: While reset is asserted, and on the first clock after it, no channel is driven, and `bus_float_o` and `hold_ack_o` are 0.
- R2: A request pulse seen while `cyc_st` = 0 (idle) produces a grant on the next clock. The grant drives that same channel's line low (`gnt_oe_o` bit 1, `gnt_val_o` bit 0) for exactly one clock.
- R3: In the grant clock, `bus_float_o` is 1 and `hold_ack_o` is 0. From the next clock until the release pulse, both are 1.
- R4: A low pulse on the owner's line during hold ends the exchange. On the next clock `hold_ack_o` and `bus_float_o` are 0 and no line is driven (the dead clock). The earliest next grant comes one clock after that.
- R5: When both channels request in the same clock, channel 0 is granted first.
- R6: A request on one channel that arrives while the other channel owns the bus is held. It is granted in the clock right after the dead clock.
- R7: While a cycle is running, a request that arrives in the first or second T-state (`cyc_st` 1 or 2) is granted in the clock after that cycle's last T-state (`cyc_st` 5), as long as no blocking input is high then.
- R8: A request that arrives in the third, wait or last T-state (`cyc_st` 3, 4 or 5) is not granted at the end of that cycle. It waits for the last T-state of a following cycle.
- R9: `odd_lo_i` (low byte of an odd word), `inta1_i` (first interrupt acknowledge) and `lock_i` (locked sequence) each block a grant at the last T-state while they are high.
- R10: At most one line is driven at a time, never for two clocks in a row, and only with the value 0.
- R11: `hold_ch_o` gives the owning channel and stays constant for the whole hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_n_i | input | NCH | Resolved level of each request/grant line, active low |
| cyc_st | input | 3 | Current T-state of the bus cycle (encoding above) |
| odd_lo_i | input | 1 | The running cycle is the low byte of an odd-address word |
| inta1_i | input | 1 | The running cycle is the first interrupt acknowledge |
| lock_i | input | 1 | A locked sequence is executing |
| gnt_oe_o | output | NCH | Drive enable of each line, high only during a grant |
| gnt_val_o | output | NCH | Value driven when enabled (always 0) |
| bus_float_o | output | 1 | The controller's bus drivers are floated |
| hold_ack_o | output | 1 | The controller is in hold-acknowledge |
| hold_ch_o | output | clog2(NCH) | Channel that owns the bus |

## Verification
A lost or stale pending request shows up as a grant that never comes after the dead clock, or as one that comes on the wrong channel. A wrong late flag moves the grant by a whole bus cycle. Both are visible on `gnt_oe_o` within one bus cycle of the stimulus. A wrong phase in the state machine shows up at once as a `bus_float_o`/`hold_ack_o` pair out of step with the grant pulse, or as a grant that lands in the dead clock. A sweep over the request's arrival phase and every mix of blocking inputs sets the grant clock exactly for each case.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

  // Bus cycle phase as presented on cyc_st
  localparam logic [2:0] TS_IDLE = 3'd0;
  localparam logic [2:0] TS_T1   = 3'd1;
  localparam logic [2:0] TS_T2   = 3'd2;
  localparam logic [2:0] TS_T3   = 3'd3;
  localparam logic [2:0] TS_TW   = 3'd4;
  localparam logic [2:0] TS_T4   = 3'd5;

  // Exchange sequencer states
  typedef enum logic [1:0] {
    XS_OPEN  = 2'd0,
    XS_GRANT = 2'd1,
    XS_HOLD  = 2'd2,
    XS_DEAD  = 2'd3
  } xstate_e;

endpackage

// File: rtl/rqgt_capture.sv
// Per-channel request memory: a pending bit and a late-arrival bit
module rqgt_capture #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rq_n_i,
  input  logic [NCH-1:0] own_drive,
  input  logic [NCH-1:0] hold_mask,
  input  logic [NCH-1:0] clr,
  input  logic           phase_late,
  input  logic           phase_new,
  output logic [NCH-1:0] want,
  output logic [NCH-1:0] late
);

  logic [NCH-1:0] pend_q, pend_d;
  logic [NCH-1:0] late_q, late_d;
  logic [NCH-1:0] new_req;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // A low level counts as a request only while this side is not driving
    // the line, and not when it is the owner's release pulse
    assign new_req[c] = ~rq_n_i[c] & ~own_drive[c] & ~hold_mask[c];
    assign want[c]    = pend_q[c] | new_req[c];
    assign late[c]    = late_q[c] | (new_req[c] & ~pend_q[c] & phase_late);

    always_comb begin
      pend_d[c] = clr[c] ? 1'b0 : want[c];
      if (clr[c] || phase_new) late_d[c] = 1'b0;
      else                     late_d[c] = late[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c] <= 1'b0;
        late_q[c] <= 1'b0;
      end else begin
        pend_q[c] <= pend_d[c];
        late_q[c] <= late_d[c];
      end
    end
  end

endmodule

// File: rtl/rqgt_gate.sv
// Decides whether the running bus cycle allows a hand-over in this clock
module rqgt_gate (
  input  logic [2:0] cyc_st,
  input  logic       odd_lo,
  input  logic       inta1,
  input  logic       lock,
  input  logic       late_win,
  output logic       go
);
  import rqgt_pkg::*;

  logic at_end, blocked;

  always_comb begin
    at_end  = (cyc_st == TS_T4);
    blocked = odd_lo | inta1 | lock | late_win;
    go      = (cyc_st == TS_IDLE) | (at_end & ~blocked);
  end

endmodule

// File: rtl/rqgt_fsm.sv
// Exchange sequencer: grant pulse, hold, dead clock
module rqgt_fsm #(
  parameter int NCH = 2,
  parameter int OW  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rq_n_i,
  input  logic           any_want,
  input  logic [OW-1:0]  win_idx,
  input  logic           go,
  output logic [NCH-1:0] gnt_oe,
  output logic [NCH-1:0] hold_mask,
  output logic [NCH-1:0] clr,
  output logic           bus_float,
  output logic           hold_ack,
  output logic [OW-1:0]  owner
);
  import rqgt_pkg::*;

  xstate_e        st_q, st_d;
  logic [OW-1:0]  own_q, own_d;
  logic [NCH-1:0] own_oh, win_oh;
  logic           take, rel;

  always_comb begin
    own_oh = NCH'(1) << own_q;
    win_oh = NCH'(1) << win_idx;
    rel    = ~rq_n_i[own_q];
    take   = any_want & go & ((st_q == XS_OPEN) | (st_q == XS_DEAD));
    st_d   = st_q;
    own_d  = own_q;
    unique case (st_q)
      XS_OPEN, XS_DEAD: begin
        if (take) begin
          st_d  = XS_GRANT;
          own_d = win_idx;
        end else begin
          st_d  = XS_OPEN;
        end
      end
      XS_GRANT: st_d = XS_HOLD;
      XS_HOLD:  if (rel) st_d = XS_DEAD;
      default:  st_d = XS_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_OPEN;
      own_q <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  always_comb begin
    clr       = take ? win_oh : '0;
    gnt_oe    = (st_q == XS_GRANT) ? own_oh : '0;
    hold_mask = (st_q == XS_HOLD)  ? own_oh : '0;
    bus_float = (st_q == XS_GRANT) | (st_q == XS_HOLD);
    hold_ack  = (st_q == XS_HOLD);
    owner     = own_q;
  end

endmodule

// File: rtl/rqgt_exchange.sv
// Top: two-or-more channel single-line request/grant bus hand-over
module rqgt_exchange #(
  parameter int NCH = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NCH-1:0]                      rq_n_i,
  input  logic [2:0]                          cyc_st,
  input  logic                                odd_lo_i,
  input  logic                                inta1_i,
  input  logic                                lock_i,
  output logic [NCH-1:0]                      gnt_oe_o,
  output logic [NCH-1:0]                      gnt_val_o,
  output logic                                bus_float_o,
  output logic                                hold_ack_o,
  output logic [$clog2(NCH>1 ? NCH : 2)-1:0]  hold_ch_o
);
  import rqgt_pkg::*;

  localparam int OW = $clog2(NCH > 1 ? NCH : 2);

  logic [NCH-1:0] want, late, clr, hold_mask, gnt_oe;
  logic [OW-1:0]  win_idx;
  logic           any_want, late_win, go, phase_late, phase_new;

  assign phase_late = (cyc_st == TS_T3) | (cyc_st == TS_TW) | (cyc_st == TS_T4);
  assign phase_new  = (cyc_st == TS_T1);

  rqgt_capture #(.NCH(NCH)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rq_n_i     (rq_n_i),
    .own_drive  (gnt_oe),
    .hold_mask  (hold_mask),
    .clr        (clr),
    .phase_late (phase_late),
    .phase_new  (phase_new),
    .want       (want),
    .late       (late)
  );

  // Fixed priority: the lowest index wins
  always_comb begin
    win_idx  = '0;
    any_want = |want;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (want[c]) win_idx = OW'(c);
    end
    late_win = late[win_idx];
  end

  rqgt_gate u_gate (
    .cyc_st   (cyc_st),
    .odd_lo   (odd_lo_i),
    .inta1    (inta1_i),
    .lock     (lock_i),
    .late_win (late_win),
    .go       (go)
  );

  rqgt_fsm #(.NCH(NCH), .OW(OW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_n_i    (rq_n_i),
    .any_want  (any_want),
    .win_idx   (win_idx),
    .go        (go),
    .gnt_oe    (gnt_oe),
    .hold_mask (hold_mask),
    .clr       (clr),
    .bus_float (bus_float_o),
    .hold_ack  (hold_ack_o),
    .owner     (hold_ch_o)
  );

  assign gnt_oe_o  = gnt_oe;
  assign gnt_val_o = '0;

endmodule

// File: rtl/rqgt_exchange_chk.sv
module rqgt_exchange_chk #(
  parameter int NCH = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [2:0]                         cyc_st,
  input logic                               odd_lo_i,
  input logic                               inta1_i,
  input logic                               lock_i,
  input logic [NCH-1:0]                     gnt_oe_o,
  input logic                               bus_float_o,
  input logic                               hold_ack_o,
  input logic [$clog2(NCH>1 ? NCH : 2)-1:0] hold_ch_o
);

  a_r10_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oe_o));

  a_r10_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_oe_o) |=> (gnt_oe_o == '0));

  a_r3_grant_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_oe_o) |-> (bus_float_o && !hold_ack_o));

  a_r3_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_oe_o) |=> (hold_ack_o && bus_float_o));

  a_r4_dead_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_o) |-> (!bus_float_o && gnt_oe_o == '0));

  a_r9_blocked_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_st == 3'd5 && (odd_lo_i || inta1_i || lock_i) && !bus_float_o)
      |=> (gnt_oe_o == '0));

  a_r11_owner_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack_o && $past(hold_ack_o)) |-> $stable(hold_ch_o));

endmodule

bind rqgt_exchange rqgt_exchange_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_st      (cyc_st),
  .odd_lo_i    (odd_lo_i),
  .inta1_i     (inta1_i),
  .lock_i      (lock_i),
  .gnt_oe_o    (gnt_oe_o),
  .bus_float_o (bus_float_o),
  .hold_ack_o  (hold_ack_o),
  .hold_ch_o   (hold_ch_o)
);

// File: tb/rqgt_exchange_bench.sv
module rqgt_exchange_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rq_n;
  logic [2:0] cyc;
  logic       odd_lo, inta1, lock;
  logic [1:0] gnt_oe, gnt_val;
  logic       bus_float, hold_ack;
  logic [0:0] hold_ch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rqgt_exchange #(.NCH(2)) u_rqgt_exchange (
    .clk         (clk),
    .rst_n       (rst_n),
    .rq_n_i      (rq_n),
    .cyc_st      (cyc),
    .odd_lo_i    (odd_lo),
    .inta1_i     (inta1),
    .lock_i      (lock),
    .gnt_oe_o    (gnt_oe),
    .gnt_val_o   (gnt_val),
    .bus_float_o (bus_float),
    .hold_ack_o  (hold_ack),
    .hold_ch_o   (hold_ch)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: the edge consumes the present inputs, then outputs settle
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic state_is(input string tag, input int g, input int f, input int h);
    check({tag, " grant"}, int'(gnt_oe), g);
    check({tag, " float"}, int'(bus_float), f);
    check({tag, " hold"}, int'(hold_ack), h);
  endtask

  task automatic pulse(input logic [1:0] lines);
    rq_n = ~lines;
    tick();
    rq_n = 2'b11;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rq_n = 2'b11; cyc = 3'd0;
    odd_lo = 1'b0; inta1 = 1'b0; lock = 1'b0;
    repeat (3) tick();
    state_is("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    tick();
    state_is("R1 after reset", 0, 0, 0);

    // R2 R3 R4 R11: idle-bus exchange on channel 0
    pulse(2'b01);
    state_is("R2 idle grant ch0", 1, 1, 0);
    check("R10 drive value", int'(gnt_val), 0);
    tick();
    state_is("R3 hold entry", 0, 1, 1);
    check("R11 owner ch0", int'(hold_ch), 0);
    repeat (3) tick();
    state_is("R3 hold kept", 0, 1, 1);
    pulse(2'b01);
    state_is("R4 dead clock", 0, 0, 0);
    tick();
    state_is("R4 settled", 0, 0, 0);

    // R2 R11: channel 1 alone
    pulse(2'b10);
    state_is("R2 idle grant ch1", 2, 1, 0);
    tick();
    check("R11 owner ch1", int'(hold_ch), 1);
    pulse(2'b10);
    state_is("R4 ch1 dead", 0, 0, 0);
    tick();

    // R5 R6: simultaneous requests, ch1 follows right after the dead clock
    pulse(2'b11);
    state_is("R5 ch0 first", 1, 1, 0);
    tick();
    pulse(2'b01);
    state_is("R6 dead before ch1", 0, 0, 0);
    tick();
    state_is("R6 ch1 after dead", 2, 1, 0);
    tick();
    check("R11 owner after switch", int'(hold_ch), 1);
    pulse(2'b10);
    tick();

    // R6: ch1 requests during ch0 hold, held until after the dead clock
    pulse(2'b01);
    tick();
    pulse(2'b10);
    state_is("R6 no grant in hold", 0, 1, 1);
    check("R6 owner unchanged", int'(hold_ch), 0);
    repeat (2) tick();
    pulse(2'b01);
    state_is("R6 dead", 0, 0, 0);
    tick();
    state_is("R6 pending served", 2, 1, 0);
    tick();
    pulse(2'b10);
    tick();

    // R7 R8 R9: sweep arrival phase and blocking inputs over a running cycle
    for (int p = 0; p < 5; p++) begin
      for (int fl = 0; fl < 8; fl++) begin
        logic [2:0] seq [0:8];
        int first;
        int exp;
        seq[0] = 3'd1; seq[1] = 3'd2; seq[2] = 3'd3; seq[3] = 3'd4; seq[4] = 3'd5;
        seq[5] = 3'd1; seq[6] = 3'd2; seq[7] = 3'd3; seq[8] = 3'd5;
        first = -1;
        exp = (p <= 1 && fl == 0) ? 4 : 8;
        for (int i = 0; i < 11; i++) begin
          cyc    = (i < 9) ? seq[i] : 3'd0;
          rq_n   = (i == p) ? 2'b10 : 2'b11;
          odd_lo = (i == 4) ? fl[0] : 1'b0;
          inta1  = (i == 4) ? fl[1] : 1'b0;
          lock   = (i == 4) ? fl[2] : 1'b0;
          tick();
          if (gnt_oe[1]) begin
            errors++; checks++;
            $display("FAIL R10 wrong line actual %0d expected 1", gnt_oe);
          end
          if (gnt_oe[0] && first < 0) first = i;
        end
        rq_n = 2'b11; odd_lo = 1'b0; inta1 = 1'b0; lock = 1'b0; cyc = 3'd0;
        if (p >= 2) check($sformatf("R8 late p%0d f%0d", p, fl), first, exp);
        else if (fl != 0) check($sformatf("R9 blocked p%0d f%0d", p, fl), first, exp);
        else check($sformatf("R7 early p%0d", p), first, exp);
        pulse(2'b01);
        tick();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule